// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the processor-facing side of an eight-line interrupt controller. It takes single-byte register writes and reads, selected by a chip-select, one address bit and read/write strobes. It turns the writes into a configuration, an interrupt mask and one-cycle command strobes for the controller core. The core itself, which holds the pending and in-service state and does the arbitration, sits outside this block. It feeds its pending and in-service vectors back in so that software can read them.

A write that starts initialization is followed by a fixed ladder of data-port writes. The vector base always comes next. A cascade word follows only when the first byte selected cascaded operation, and an options word follows only when the first byte asked for one. Once the ladder is complete the block is in run mode. Data-port writes then load the mask, and command-port writes issue end-of-interrupt and rotation commands, pick the read source, or arm a one-shot poll read.

Top module: `ic_cmd_if`

## Requirements
- R1: After reset the mask is all zero, `cfg_ready` is low, rotation is off, poll is disarmed, all strobes are low, and a command-port read (`addr`=0) returns `pend_vec`.
- R2: A write with `addr`=0 and data bit 4 set restarts initialization from any state. It latches bit 0 (options word follows), bit 1 (single, no cascade word), bit 2 (processor family) and bit 3 (slave role). It clears the mask, the rotating-priority flag, the poll arm, the read select (back to pending), the cascade map and the options, and drops `cfg_ready`.
- R3: The next data-port write (`addr`=1) after R2 is the vector base word: `vec_base` takes data bits 7..3.
- R4: In cascaded mode (bit 1 clear) the data-port write after the base word is the cascade word. It is stored whole in `casc_map`, and `casc_id` shows its bits 2..0 when the slave role is set and zero otherwise. In single mode this word is skipped.
- R5: The options word is expected only when bit 0 was set. Its bit 0 sets `opt_aeoi`, bit 1 sets `opt_buf` and bit 2 sets `opt_sfnm`. `cfg_ready` rises after the last expected word and stays high until the next R2 write.
- R6: Before `cfg_ready`, command-port writes with bit 4 clear have no effect: no strobe, and the read source does not change.
- R7: In run mode a data-port write loads `irq_mask` with the byte, and a data-port read returns `irq_mask`. No other write changes the mask except R2.
- R8: In run mode a command-port write with bits 4 and 3 clear is decoded on bits 7..5. 001 pulses `eoi_ns_stb`; 011 pulses `eoi_sp_stb` with `eoi_lvl` = bits 2..0; 101 pulses `rot_eoi_stb`; 100 sets `rot_prio`; 000 clears it; other codes have no effect. Each strobe is high for exactly the cycle after the write.
- R9: In run mode a command-port write with bit 4 clear and bit 3 set changes the read source when bit 1 is set: bit 0 = 0 selects pending and 1 selects in-service. Bit 2 arms poll.
- R10: While poll is armed, the next command-port read returns bit 7 = any unmasked pending line and bits 2..0 = the lowest-numbered unmasked pending line, with other bits zero. That read disarms poll. If a line was pending, `poll_ack_stb` pulses the next cycle with `poll_lvl` = that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, qualifies both strobes |
| addr | input | 1 | 0 = command port, 1 = data port |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| wdata | input | 8 | Write data byte |
| pend_vec | input | 8 | Pending-request vector from the core |
| insvc_vec | input | 8 | In-service vector from the core |
| rdata | output | 8 | Read data, combinational on `addr` and state |
| cfg_ready | output | 1 | Initialization complete |
| cfg_single | output | 1 | Single-controller operation |
| cfg_family | output | 1 | Processor-family select |
| cfg_slave | output | 1 | Slave role in a cascade |
| cfg_need4 | output | 1 | Options word requested |
| vec_base | output | 5 | Vector base bits |
| casc_map | output | 8 | Cascade word (slave-line bitmap for a master) |
| casc_id | output | 3 | Slave identity |
| opt_aeoi | output | 1 | Automatic end-of-interrupt |
| opt_buf | output | 1 | Buffered bus mode |
| opt_sfnm | output | 1 | Special fully nested mode |
| irq_mask | output | 8 | Interrupt mask |
| rot_prio | output | 1 | Rotating priority enabled |
| eoi_ns_stb | output | 1 | Non-specific end-of-interrupt strobe |
| eoi_sp_stb | output | 1 | Specific end-of-interrupt strobe |
| rot_eoi_stb | output | 1 | Rotate-on-end-of-interrupt strobe |
| eoi_lvl | output | 3 | Level for the specific end-of-interrupt |
| poll_armed | output | 1 | Poll read armed |
| poll_ack_stb | output | 1 | Poll read acknowledged a line |
| poll_lvl | output | 3 | Line acknowledged by the poll read |

## Verification
The embedded properties assume that at most one of a write and a read reaches the block in any cycle. They also assume that each strobe lasts one cycle and that `pend_vec` is steady during a poll read. The stimulus changes inputs only on the falling edge and issues one access per cycle with idle cycles between accesses, so none of these assumptions is broken. A behavioural model of the write ladder and the run-time registers is compared with every output on each cycle. It covers restarts in the middle of the ladder, all three ladder lengths, commands written before initialization, and poll reads with and without a pending line.

// File: rtl/ic_cmd_pkg.sv
// Shared types for the interrupt controller command interface.
// Assumes an eight-line controller with byte-wide command words.
package ic_cmd_pkg;

    // Position in the initialization ladder
    typedef enum logic [2:0] {
        SEQ_W1  = 3'd0,
        SEQ_W2  = 3'd1,
        SEQ_W3  = 3'd2,
        SEQ_W4  = 3'd3,
        SEQ_RUN = 3'd4
    } seq_t;

    // Kind of write seen this cycle
    typedef enum logic [2:0] {
        WK_NONE  = 3'd0,
        WK_INIT1 = 3'd1,
        WK_DATA  = 3'd2,
        WK_OPW2  = 3'd3,
        WK_OPW3  = 3'd4
    } wkind_t;

    // Second operation word command codes (data bits 7..5)
    localparam logic [2:0] OP_ROT_OFF = 3'b000;
    localparam logic [2:0] OP_NS_EOI  = 3'b001;
    localparam logic [2:0] OP_SP_EOI  = 3'b011;
    localparam logic [2:0] OP_ROT_ON  = 3'b100;
    localparam logic [2:0] OP_ROT_EOI = 3'b101;

endpackage

// File: rtl/ic_wr_decode.sv
// Classifies a bus write into a start-of-init, data-port or operation word.
// Assumes sel qualifies wr_stb; pure combinational.
module ic_wr_decode
    import ic_cmd_pkg::*;
(
    input  logic       sel,
    input  logic       addr,
    input  logic       wr_stb,
    input  logic [4:3] wbits,
    output wkind_t     kind
);

    // Decode the write kind from address and two data flags
    always_comb begin
        if (!(sel && wr_stb))  kind = WK_NONE;
        else if (addr)         kind = WK_DATA;
        else if (wbits[4])     kind = WK_INIT1;
        else if (wbits[3])     kind = WK_OPW3;
        else                   kind = WK_OPW2;
    end

endmodule

// File: rtl/ic_lowest_pick.sv
// Finds the lowest-numbered set bit of a request vector.
// Assumes NL is a power of two; combinational.
module ic_lowest_pick #(
    parameter int NL = 8,
    localparam int LW = $clog2(NL)
) (
    input  logic [NL-1:0] req,
    output logic          any,
    output logic [LW-1:0] lvl
);

    // Scan from the top so the lowest set index wins
    always_comb begin
        lvl = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (req[i]) lvl = LW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/ic_init_seq.sv
// Initialization ladder: first word, base word, optional cascade word,
// optional options word. Holds the configuration fields.
// Assumes at most one write per cycle.
module ic_init_seq
    import ic_cmd_pkg::*;
#(
    parameter int NL = 8,
    localparam int LW = $clog2(NL),
    localparam int VBW = NL - LW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  wkind_t         kind,
    input  logic [NL-1:0]  wdata,
    output logic           run,
    output logic           cfg_single,
    output logic           cfg_family,
    output logic           cfg_slave,
    output logic           cfg_need4,
    output logic [VBW-1:0] vec_base,
    output logic [NL-1:0]  casc_map,
    output logic           opt_aeoi,
    output logic           opt_buf,
    output logic           opt_sfnm
);

    seq_t state;

    // Advance the ladder and latch each word's fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_W1;
            cfg_single <= 1'b0;
            cfg_family <= 1'b0;
            cfg_slave  <= 1'b0;
            cfg_need4  <= 1'b0;
            vec_base   <= '0;
            casc_map   <= '0;
            opt_aeoi   <= 1'b0;
            opt_buf    <= 1'b0;
            opt_sfnm   <= 1'b0;
        end else if (kind == WK_INIT1) begin
            state      <= SEQ_W2;
            cfg_need4  <= wdata[0];
            cfg_single <= wdata[1];
            cfg_family <= wdata[2];
            cfg_slave  <= wdata[3];
            casc_map   <= '0;
            opt_aeoi   <= 1'b0;
            opt_buf    <= 1'b0;
            opt_sfnm   <= 1'b0;
        end else if (kind == WK_DATA) begin
            case (state)
                SEQ_W2: begin
                    vec_base <= wdata[NL-1:LW];
                    if (!cfg_single)   state <= SEQ_W3;
                    else if (cfg_need4) state <= SEQ_W4;
                    else               state <= SEQ_RUN;
                end
                SEQ_W3: begin
                    casc_map <= wdata;
                    state    <= cfg_need4 ? SEQ_W4 : SEQ_RUN;
                end
                SEQ_W4: begin
                    opt_aeoi <= wdata[0];
                    opt_buf  <= wdata[1];
                    opt_sfnm <= wdata[2];
                    state    <= SEQ_RUN;
                end
                default: ;
            endcase
        end
    end

    assign run = (state == SEQ_RUN);

    // A first word always lands in the base-word slot
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kind == WK_INIT1 |=> (state == SEQ_W2 && !run));

    // Run mode is left only through a new first word
    assert_run_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kind != WK_INIT1) |=> run);

endmodule

// File: rtl/ic_oper_regs.sv
// Run-time registers: mask, rotation flag, read select, poll arm and the
// one-cycle command strobes. Assumes a read and a write never share a cycle.
module ic_oper_regs
    import ic_cmd_pkg::*;
#(
    parameter int NL = 8,
    localparam int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wkind_t        kind,
    input  logic [NL-1:0] wdata,
    input  logic          run,
    input  logic          poll_rd,
    input  logic          pick_any,
    input  logic [LW-1:0] pick_lvl,
    output logic [NL-1:0] irq_mask,
    output logic          rot_prio,
    output logic          rd_isr,
    output logic          poll_armed,
    output logic          eoi_ns_stb,
    output logic          eoi_sp_stb,
    output logic          rot_eoi_stb,
    output logic [LW-1:0] eoi_lvl,
    output logic          poll_ack_stb,
    output logic [LW-1:0] poll_lvl
);

    // Update run-time state and emit single-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_mask     <= '0;
            rot_prio     <= 1'b0;
            rd_isr       <= 1'b0;
            poll_armed   <= 1'b0;
            eoi_ns_stb   <= 1'b0;
            eoi_sp_stb   <= 1'b0;
            rot_eoi_stb  <= 1'b0;
            eoi_lvl      <= '0;
            poll_ack_stb <= 1'b0;
            poll_lvl     <= '0;
        end else begin
            eoi_ns_stb   <= 1'b0;
            eoi_sp_stb   <= 1'b0;
            rot_eoi_stb  <= 1'b0;
            poll_ack_stb <= 1'b0;
            if (kind == WK_INIT1) begin
                irq_mask   <= '0;
                rot_prio   <= 1'b0;
                rd_isr     <= 1'b0;
                poll_armed <= 1'b0;
            end else if (run) begin
                case (kind)
                    WK_DATA: irq_mask <= wdata;
                    WK_OPW2: begin
                        case (wdata[7:5])
                            OP_NS_EOI:  eoi_ns_stb <= 1'b1;
                            OP_SP_EOI: begin
                                eoi_sp_stb <= 1'b1;
                                eoi_lvl    <= wdata[LW-1:0];
                            end
                            OP_ROT_EOI: rot_eoi_stb <= 1'b1;
                            OP_ROT_ON:  rot_prio <= 1'b1;
                            OP_ROT_OFF: rot_prio <= 1'b0;
                            default: ;
                        endcase
                    end
                    WK_OPW3: begin
                        if (wdata[1]) rd_isr <= wdata[0];
                        if (wdata[2]) poll_armed <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (poll_rd) begin
                poll_armed   <= 1'b0;
                poll_ack_stb <= pick_any;
                poll_lvl     <= pick_lvl;
            end
        end
    end

    // Command strobes never overlap
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eoi_ns_stb, eoi_sp_stb, rot_eoi_stb}));

    // No command strobe follows a write made before run mode
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(eoi_ns_stb || eoi_sp_stb || rot_eoi_stb));

    // The mask moves only on a data write or a restart
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WK_DATA && kind != WK_INIT1) |=> $stable(irq_mask));

    // A poll acknowledge consumes the armed poll
    assert_poll_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ack_stb |-> ($past(poll_armed) && !poll_armed));

endmodule

// File: rtl/ic_cmd_if.sv
// Top of the command interface: write decode, initialization ladder,
// run-time registers and the read-data mux with poll byte.
// Assumes one access per cycle and strobes qualified by sel.
module ic_cmd_if
    import ic_cmd_pkg::*;
#(
    parameter int NL = 8,
    localparam int LW = $clog2(NL),
    localparam int VBW = NL - LW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           addr,
    input  logic           wr_stb,
    input  logic           rd_stb,
    input  logic [NL-1:0]  wdata,
    input  logic [NL-1:0]  pend_vec,
    input  logic [NL-1:0]  insvc_vec,
    output logic [NL-1:0]  rdata,
    output logic           cfg_ready,
    output logic           cfg_single,
    output logic           cfg_family,
    output logic           cfg_slave,
    output logic           cfg_need4,
    output logic [VBW-1:0] vec_base,
    output logic [NL-1:0]  casc_map,
    output logic [LW-1:0]  casc_id,
    output logic           opt_aeoi,
    output logic           opt_buf,
    output logic           opt_sfnm,
    output logic [NL-1:0]  irq_mask,
    output logic           rot_prio,
    output logic           eoi_ns_stb,
    output logic           eoi_sp_stb,
    output logic           rot_eoi_stb,
    output logic [LW-1:0]  eoi_lvl,
    output logic           poll_armed,
    output logic           poll_ack_stb,
    output logic [LW-1:0]  poll_lvl
);

    wkind_t        kind;
    logic          rd_isr;
    logic          pick_any;
    logic [LW-1:0] pick_lvl;
    logic          poll_rd;

    ic_wr_decode u_dec (
        .sel    (sel),
        .addr   (addr),
        .wr_stb (wr_stb),
        .wbits  (wdata[4:3]),
        .kind   (kind)
    );

    ic_init_seq #(.NL(NL)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .wdata      (wdata),
        .run        (cfg_ready),
        .cfg_single (cfg_single),
        .cfg_family (cfg_family),
        .cfg_slave  (cfg_slave),
        .cfg_need4  (cfg_need4),
        .vec_base   (vec_base),
        .casc_map   (casc_map),
        .opt_aeoi   (opt_aeoi),
        .opt_buf    (opt_buf),
        .opt_sfnm   (opt_sfnm)
    );

    ic_lowest_pick #(.NL(NL)) u_pick (
        .req (pend_vec & ~irq_mask),
        .any (pick_any),
        .lvl (pick_lvl)
    );

    assign poll_rd = sel && rd_stb && !addr && poll_armed;

    ic_oper_regs #(.NL(NL)) u_ops (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind         (kind),
        .wdata        (wdata),
        .run          (cfg_ready),
        .poll_rd      (poll_rd),
        .pick_any     (pick_any),
        .pick_lvl     (pick_lvl),
        .irq_mask     (irq_mask),
        .rot_prio     (rot_prio),
        .rd_isr       (rd_isr),
        .poll_armed   (poll_armed),
        .eoi_ns_stb   (eoi_ns_stb),
        .eoi_sp_stb   (eoi_sp_stb),
        .rot_eoi_stb  (rot_eoi_stb),
        .eoi_lvl      (eoi_lvl),
        .poll_ack_stb (poll_ack_stb),
        .poll_lvl     (poll_lvl)
    );

    // Slave identity is meaningful only in the slave role
    assign casc_id = cfg_slave ? casc_map[LW-1:0] : '0;

    // Read mux: mask on the data port, poll byte or selected vector otherwise
    always_comb begin
        if (addr)            rdata = irq_mask;
        else if (poll_armed) rdata = {pick_any, {(NL-1-LW){1'b0}}, pick_lvl};
        else if (rd_isr)     rdata = insvc_vec;
        else                 rdata = pend_vec;
    end

endmodule

// File: tb/ic_cmd_if_tb_top.sv
`timescale 1ns/1ps
module ic_cmd_if_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, addr = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] wdata = '0, pend_vec = '0, insvc_vec = '0;
    logic [7:0] rdata, casc_map, irq_mask;
    logic [4:0] vec_base;
    logic [2:0] casc_id, eoi_lvl, poll_lvl;
    logic cfg_ready, cfg_single, cfg_family, cfg_slave, cfg_need4;
    logic opt_aeoi, opt_buf, opt_sfnm, rot_prio;
    logic eoi_ns_stb, eoi_sp_stb, rot_eoi_stb, poll_armed, poll_ack_stb;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ic_cmd_if dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wdata(wdata), .pend_vec(pend_vec), .insvc_vec(insvc_vec),
        .rdata(rdata), .cfg_ready(cfg_ready), .cfg_single(cfg_single),
        .cfg_family(cfg_family), .cfg_slave(cfg_slave), .cfg_need4(cfg_need4),
        .vec_base(vec_base), .casc_map(casc_map), .casc_id(casc_id),
        .opt_aeoi(opt_aeoi), .opt_buf(opt_buf), .opt_sfnm(opt_sfnm),
        .irq_mask(irq_mask), .rot_prio(rot_prio), .eoi_ns_stb(eoi_ns_stb),
        .eoi_sp_stb(eoi_sp_stb), .rot_eoi_stb(rot_eoi_stb), .eoi_lvl(eoi_lvl),
        .poll_armed(poll_armed), .poll_ack_stb(poll_ack_stb), .poll_lvl(poll_lvl)
    );

    // Reference model state
    int m_ph;               // 0 none, 1 base next, 2 cascade next, 3 options next, 4 run
    bit m_single, m_need4, m_fam, m_slave, m_aeoi, m_buf, m_sfnm;
    bit m_rot, m_isr, m_poll, m_ns, m_sp, m_re, m_pack;
    int m_vec, m_casc, m_mask, m_lvl, m_plvl;

    function automatic int lowest(input int v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic int exp_rdata();
        int req;
        req = pend_vec & ~m_mask & 8'hFF;
        if (addr) return m_mask;
        if (m_poll) return ((req != 0) ? 8'h80 : 0) | lowest(req);
        return m_isr ? insvc_vec : pend_vec;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_single = 0; m_need4 = 0; m_fam = 0; m_slave = 0;
            m_aeoi = 0; m_buf = 0; m_sfnm = 0; m_rot = 0; m_isr = 0; m_poll = 0;
            m_ns = 0; m_sp = 0; m_re = 0; m_pack = 0; m_vec = 0; m_casc = 0;
            m_mask = 0; m_lvl = 0; m_plvl = 0;
        end else begin
            m_ns = 0; m_sp = 0; m_re = 0; m_pack = 0;
            if (sel && rd_stb && !addr && m_poll) begin
                int req;
                req = pend_vec & ~m_mask & 8'hFF;
                m_pack = (req != 0);
                m_plvl = lowest(req);
                m_poll = 0;
            end
            if (sel && wr_stb) begin
                if (!addr && wdata[4]) begin
                    m_ph = 1; m_need4 = wdata[0]; m_single = wdata[1];
                    m_fam = wdata[2]; m_slave = wdata[3];
                    m_casc = 0; m_aeoi = 0; m_buf = 0; m_sfnm = 0;
                    m_mask = 0; m_rot = 0; m_isr = 0; m_poll = 0;
                end else if (addr) begin
                    case (m_ph)
                        1: begin m_vec = wdata >> 3;
                                 m_ph = !m_single ? 2 : (m_need4 ? 3 : 4); end
                        2: begin m_casc = wdata; m_ph = m_need4 ? 3 : 4; end
                        3: begin m_aeoi = wdata[0]; m_buf = wdata[1];
                                 m_sfnm = wdata[2]; m_ph = 4; end
                        4: m_mask = wdata;
                        default: ;
                    endcase
                end else if (m_ph == 4) begin
                    if (wdata[3]) begin
                        if (wdata[1]) m_isr = wdata[0];
                        if (wdata[2]) m_poll = 1;
                    end else begin
                        case (wdata[7:5])
                            3'b001: m_ns = 1;
                            3'b011: begin m_sp = 1; m_lvl = wdata[2:0]; end
                            3'b101: m_re = 1;
                            3'b100: m_rot = 1;
                            3'b000: m_rot = 0;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // Compare every registered output with the model on each falling edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            chk("R5 cfg_ready", cfg_ready, m_ph == 4);
            chk("R2 cfg_single", cfg_single, m_single);
            chk("R2 cfg_need4", cfg_need4, m_need4);
            chk("R2 cfg_family", cfg_family, m_fam);
            chk("R2 cfg_slave", cfg_slave, m_slave);
            chk("R3 vec_base", vec_base, m_vec);
            chk("R4 casc_map", casc_map, m_casc);
            chk("R4 casc_id", casc_id, m_slave ? (m_casc & 7) : 0);
            chk("R5 opt_aeoi", opt_aeoi, m_aeoi);
            chk("R5 opt_buf", opt_buf, m_buf);
            chk("R5 opt_sfnm", opt_sfnm, m_sfnm);
            chk("R7 irq_mask", irq_mask, m_mask);
            chk("R8 rot_prio", rot_prio, m_rot);
            chk("R8 eoi_ns_stb", eoi_ns_stb, m_ns);
            chk("R8 eoi_sp_stb", eoi_sp_stb, m_sp);
            chk("R8 rot_eoi_stb", rot_eoi_stb, m_re);
            if (m_sp) chk("R8 eoi_lvl", eoi_lvl, m_lvl);
            chk("R9 poll_armed", poll_armed, m_poll);
            chk("R10 poll_ack_stb", poll_ack_stb, m_pack);
            if (m_pack) chk("R10 poll_lvl", poll_lvl, m_plvl);
        end
    end

    // One bus access, then one idle cycle
    task automatic wr(input bit a, input logic [7:0] d);
        @(negedge clk);
        sel = 1; addr = a; wr_stb = 1; wdata = d;
        @(negedge clk);
        sel = 0; wr_stb = 0; addr = 0;
    endtask

    task automatic rd(input bit a, input string tag);
        @(negedge clk);
        sel = 1; addr = a; rd_stb = 1;
        #1 chk(tag, rdata, exp_rdata());
        @(negedge clk);
        sel = 0; rd_stb = 0; addr = 0;
    endtask

    initial begin
        pend_vec = 8'hA5; insvc_vec = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_en = 1;
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1 mask", irq_mask, 0);
        chk("R1 ready", cfg_ready, 0);
        chk("R1 strobes", {eoi_ns_stb, eoi_sp_stb, rot_eoi_stb, poll_ack_stb}, 0);
        rd(0, "R1 read pending");
        // R6 operation words before initialization
        wr(0, 8'h20);
        wr(0, 8'h0F);
        rd(0, "R6 read source unchanged");
        chk("R6 poll not armed", poll_armed, 0);
        // Single mode with options word
        wr(0, 8'h13);
        wr(1, 8'h48);
        chk("R5 not ready before options", cfg_ready, 0);
        wr(1, 8'h05);
        // R7 mask load and read back
        wr(1, 8'hF0);
        rd(1, "R7 read mask");
        // R8 command words
        wr(0, 8'h20);
        wr(0, 8'h63);
        wr(0, 8'hA0);
        wr(0, 8'h80);
        wr(0, 8'h40);
        wr(0, 8'h00);
        wr(0, 8'hE7);
        wr(0, 8'h80);
        // R9 read select
        wr(0, 8'h0B);
        rd(0, "R9 read in-service");
        wr(0, 8'h08);
        rd(0, "R9 unchanged without bit1");
        wr(0, 8'h0A);
        rd(0, "R9 read pending");
        // R10 poll with a pending unmasked line
        pend_vec = 8'h30;
        wr(1, 8'h10);
        wr(0, 8'h0C);
        rd(0, "R10 poll byte");
        rd(0, "R10 poll disarmed");
        // R10 poll with nothing pending
        pend_vec = 8'h00;
        wr(0, 8'h0C);
        rd(0, "R10 empty poll byte");
        // R2 restart clears run state; cascaded master, no options
        wr(0, 8'h0C);
        wr(0, 8'h10);
        rd(0, "R2 read back to pending");
        wr(1, 8'hF8);
        chk("R4 cascade word expected", cfg_ready, 0);
        wr(1, 8'h04);
        wr(1, 8'h55);
        // Cascaded slave with options, restarted mid-ladder
        wr(0, 8'h19);
        wr(1, 8'h20);
        wr(0, 8'h1D);
        wr(1, 8'h28);
        wr(1, 8'h0A);
        wr(1, 8'h02);
        wr(0, 8'h63);
        rd(1, "R7 mask after restart");
        // Single mode without options
        wr(0, 8'h16);
        wr(1, 8'hB0);
        wr(1, 8'h81);
        rd(1, "R7 mask in short ladder");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule